// File: doc/BRIEF.md
# Frequency-Locked Loop Integrator

This block holds a digitally controlled oscillator at a chosen multiple of a slow reference clock. The oscillator clock is divided, first by a power-of-two factor D and then by an integer N+1. Each period of that divided signal lowers a 10-bit integrator by one, and each period of the reference raises it by one. When the oscillator runs fast the integrator falls. When it runs slow the integrator climbs. At lock, the oscillator frequency is D·(N+1) times the reference frequency.

The integrator value drives the oscillator directly. Its top five bits choose one of the coarse frequency taps, and each tap is roughly ten percent faster than the one below it. Its bottom five bits form a fractional code that tells the oscillator how to mix a tap with the next one up. A separate output delivers the oscillator clock, either after division by D or undivided. The raw integrator value is available for readback.

Both slow events cross into the system clock domain through synchronizers and edge detectors. The integrator then counts them. When an up event and a down event arrive in the same cycle they cancel. The integrator clamps at its ends instead of wrapping around.

Top module: `fll_integrator`

## Requirements
- R1: Synchronous active-low reset clears the integrator readback, the tap select and the modulation code to 0.
- R2: Each rising edge of the reference clock raises the integrator by exactly 1.
- R3: Each D·(N+1) oscillator periods lower the integrator by exactly 1. D = 2^div_sel, so codes 0, 1, 2 and 3 give D = 1, 2, 4 and 8, and N is the 7-bit mult_n value.
- R4: If reference and divided-oscillator events occur at equal rates, the integrator holds its value, and coincident events cancel.
- R5: The integrator stops at 1023 and does not wrap under further up events.
- R6: The integrator stops at 0 and does not wrap under further down events.
- R7: tap_sel equals integrator bits [9:5] when they are at most 28. Raw values 28 to 31 all give tap_sel = 28.
- R8: mod_code equals integrator bits [4:0] while mod_off = 0. It is 0 while mod_off = 1, and the integrator itself is unaffected by mod_off.
- R9: With out_undiv = 0, osc_out carries the oscillator clock divided by D (undivided when D = 1). With out_undiv = 1, it carries the undivided oscillator clock.
- R10: In a closed loop with an oscillator whose period shrinks by 10% per tap step, the integrator settles where the oscillator frequency is D·(N+1) times the reference frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which the integrator runs |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_clk | input | 1 | Slow reference clock; each rising edge counts up |
| osc_clk | input | 1 | Clock coming back from the controlled oscillator |
| div_sel | input | 2 | Divider code, D = 2^div_sel |
| mult_n | input | 7 | Multiplier N; the feedback divides by N+1 after D |
| out_undiv | input | 1 | 1 delivers the undivided oscillator clock on osc_out |
| mod_off | input | 1 | 1 forces the modulation code to 0 |
| tap_sel | output | 5 | Coarse oscillator tap, clamped at 28 |
| mod_code | output | 5 | Fractional modulation code |
| osc_out | output | 1 | Oscillator clock, divided by D or undivided |
| integ_q | output | 10 | Integrator readback |

## Verification
The checks rest on four conditions about the inputs. Each level of ref_clk must last at least two system clock cycles, and so must each level of the divided-oscillator toggle. Under those conditions every event becomes a single-cycle pulse, and no event can be lost in the synchronizers. The divider code and N may change only while the oscillator is stopped. ref_clk must be low when reset is released. The stimulus respects these limits in the following ways:
- It keeps every reference half-period at three system cycles or more.
- It keeps every feedback toggle interval well above two cycles.
- It changes div_sel and mult_n only between oscillator bursts.
- It delivers oscillator periods in whole multiples of D·(N+1), so the expected decrement count does not depend on the divider's starting phase.

// File: rtl/fll_pkg.sv
// Shared sizing for the frequency-locked loop integrator.
// Assumes the integrator splits into a coarse tap field on top and a
// fractional modulation field below it.
package fll_pkg;
    localparam int FLL_INTEG_W  = 10;  // integrator width
    localparam int FLL_TAP_W    = 5;   // coarse tap field width
    localparam int FLL_TAP_LAST = 28;  // highest distinct tap
    localparam int FLL_DSEL_W   = 2;   // divider code width
    localparam int FLL_N_W      = 7;   // multiplier width
endpackage

// File: rtl/fll_osc_divider.sv
// Oscillator-domain divider chain: divide-by-D prescaler, then divide-by-(N+1)
// counter whose wrap toggles a feedback level once per divided period.
// Also selects the delivered clock (divided by D or raw).
// Assumes div_sel and mult_n change only while osc_clk is stopped.
module fll_osc_divider #(
    parameter int DSEL_W = 2,
    parameter int N_W    = 7
) (
    input  logic              osc_clk,
    input  logic              rst_n,
    input  logic [DSEL_W-1:0] div_sel,
    input  logic [N_W-1:0]    mult_n,
    input  logic              out_undiv,
    output logic              osc_out,
    output logic              fb_tgl
);
    localparam int DCNT_W = (1 << DSEL_W) - 1;  // holds D-1 for the largest D

    logic [1:0]        orst_q;
    logic              orst_n;
    logic [DCNT_W:0]   d_full;
    logic [DCNT_W-1:0] d_last;
    logic [DCNT_W-1:0] d_half;
    logic [DCNT_W-1:0] cnt_d;
    logic [DCNT_W-1:0] cnt_d_nxt;
    logic              d_wrap;
    logic              divd_q;
    logic [N_W-1:0]    cnt_n;
    logic              fb_q;
    logic              osc_div;

    // Reset synchronizer into the oscillator domain.
    always_ff @(posedge osc_clk) begin
        orst_q <= {orst_q[0], rst_n};
    end
    assign orst_n = orst_q[1];

    // Decode the divider code into terminal count and half point.
    always_comb begin
        d_full = (DCNT_W+1)'(1) << div_sel;
        d_last = DCNT_W'(d_full - (DCNT_W+1)'(1));
        d_half = DCNT_W'(d_full >> 1);
    end

    // Next prescaler count and wrap flag.
    always_comb begin
        d_wrap    = (cnt_d >= d_last);
        cnt_d_nxt = d_wrap ? '0 : cnt_d + DCNT_W'(1);
    end

    // Prescaler counter and registered divided clock (high for the first half).
    always_ff @(posedge osc_clk) begin
        if (!orst_n) begin
            cnt_d  <= '0;
            divd_q <= 1'b0;
        end else begin
            cnt_d  <= cnt_d_nxt;
            divd_q <= (cnt_d_nxt < d_half);
        end
    end

    // Divide-by-(N+1) stage; toggles the feedback level on each wrap.
    always_ff @(posedge osc_clk) begin
        if (!orst_n) begin
            cnt_n <= '0;
            fb_q  <= 1'b0;
        end else if (d_wrap) begin
            if (cnt_n >= mult_n) begin
                cnt_n <= '0;
                fb_q  <= ~fb_q;
            end else begin
                cnt_n <= cnt_n + N_W'(1);
            end
        end
    end

    // Delivered clock selection: raw when D is 1 or bypass requested.
    always_comb begin
        osc_div = (div_sel == '0) ? osc_clk : divd_q;
        osc_out = out_undiv ? osc_clk : osc_div;
    end

    assign fb_tgl = fb_q;
endmodule

// File: rtl/fll_edge_sync.sv
// Two-flop synchronizer with edge detector into the system clock domain.
// ANY_EDGE=0 pulses on rising edges, ANY_EDGE=1 pulses on every transition.
// Assumes each input level lasts at least two system clock cycles.
module fll_edge_sync #(
    parameter bit ANY_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic evt
);
    logic [2:0] sync_q;

    // Synchronizer chain plus history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[1:0], async_in};
    end

    // Edge detector variant picked by parameter.
    generate
        if (ANY_EDGE) begin : g_any
            assign evt = sync_q[1] ^ sync_q[2];
        end else begin : g_rise
            assign evt = sync_q[1] & ~sync_q[2];
        end
    endgenerate

    AST_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> !evt) else $error("event pulse longer than one cycle"); // R2
endmodule

// File: rtl/fll_accum.sv
// Saturating up/down integrator. Up and down in the same cycle cancel;
// the value clamps at 0 and at all-ones.
module fll_accum #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         up_evt,
    input  logic         dn_evt,
    output logic [W-1:0] q
);
    localparam logic [W-1:0] QMAX = '1;

    logic inc_ok;
    logic dec_ok;

    // Step qualification: one direction only, and not already at the end.
    always_comb begin
        inc_ok = up_evt && !dn_evt && (q != QMAX);
        dec_ok = dn_evt && !up_evt && (q != '0);
    end

    // Integrator register.
    always_ff @(posedge clk) begin
        if (!rst_n)      q <= '0;
        else if (inc_ok) q <= q + W'(1);
        else if (dec_ok) q <= q - W'(1);
    end

    AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (up_evt && !dn_evt && q != QMAX) |=> (q == $past(q) + W'(1))) else $error("up step"); // R2
    AST_DN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_evt && !up_evt && q != '0) |=> (q == $past(q) - W'(1))) else $error("down step"); // R3
    AST_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
        (up_evt && dn_evt) |=> $stable(q)) else $error("cancel"); // R4
    AST_SAT_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (q == QMAX && !dn_evt) |=> (q == QMAX)) else $error("top clamp"); // R5
    AST_SAT_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (q == '0 && !up_evt) |=> (q == '0)) else $error("bottom clamp"); // R6
endmodule

// File: rtl/fll_code_map.sv
// Splits the integrator into the oscillator controls: a coarse tap clamped at
// the last distinct tap, and a fractional code that can be forced to zero.
module fll_code_map #(
    parameter int INTEG_W  = 10,
    parameter int TAP_W    = 5,
    parameter int TAP_LAST = 28
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [INTEG_W-1:0]       integ,
    input  logic                     mod_off,
    output logic [TAP_W-1:0]         tap,
    output logic [INTEG_W-TAP_W-1:0] mod_code
);
    localparam int MOD_W = INTEG_W - TAP_W;
    localparam logic [TAP_W-1:0] TAP_CAP = TAP_W'(TAP_LAST);

    logic [TAP_W-1:0] tap_raw;

    // Coarse field with clamp of the non-distinct top codes.
    always_comb begin
        tap_raw = integ[INTEG_W-1:MOD_W];
        tap     = (tap_raw > TAP_CAP) ? TAP_CAP : tap_raw;
    end

    // Fractional field, gated by the modulation disable.
    always_comb begin
        mod_code = mod_off ? '0 : integ[MOD_W-1:0];
    end

    AST_TAP_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(integ) == integ) |-> $stable(tap)) else $error("tap moved without integrator"); // R7
endmodule

// File: rtl/fll_integrator.sv
// Frequency-locked loop integrator top. The reference clock counts up and the
// oscillator divided by D*(N+1) counts down a saturating integrator whose
// fields drive the oscillator tap and modulation code.
// Assumes slow ref_clk and feedback levels (>= 2 clk cycles each) and static
// divider settings while the oscillator runs.
module fll_integrator
    import fll_pkg::*;
#(
    parameter int INTEG_W  = FLL_INTEG_W,
    parameter int TAP_W    = FLL_TAP_W,
    parameter int TAP_LAST = FLL_TAP_LAST,
    parameter int DSEL_W   = FLL_DSEL_W,
    parameter int N_W      = FLL_N_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ref_clk,
    input  logic                     osc_clk,
    input  logic [DSEL_W-1:0]        div_sel,
    input  logic [N_W-1:0]           mult_n,
    input  logic                     out_undiv,
    input  logic                     mod_off,
    output logic [TAP_W-1:0]         tap_sel,
    output logic [INTEG_W-TAP_W-1:0] mod_code,
    output logic                     osc_out,
    output logic [INTEG_W-1:0]       integ_q
);
    logic fb_tgl;
    logic up_evt;
    logic dn_evt;

    fll_osc_divider #(.DSEL_W(DSEL_W), .N_W(N_W)) u_div (
        .osc_clk  (osc_clk),
        .rst_n    (rst_n),
        .div_sel  (div_sel),
        .mult_n   (mult_n),
        .out_undiv(out_undiv),
        .osc_out  (osc_out),
        .fb_tgl   (fb_tgl)
    );

    fll_edge_sync #(.ANY_EDGE(1'b0)) u_ref_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(ref_clk),
        .evt     (up_evt)
    );

    fll_edge_sync #(.ANY_EDGE(1'b1)) u_fb_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(fb_tgl),
        .evt     (dn_evt)
    );

    fll_accum #(.W(INTEG_W)) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .up_evt(up_evt),
        .dn_evt(dn_evt),
        .q     (integ_q)
    );

    fll_code_map #(.INTEG_W(INTEG_W), .TAP_W(TAP_W), .TAP_LAST(TAP_LAST)) u_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .integ   (integ_q),
        .mod_off (mod_off),
        .tap     (tap_sel),
        .mod_code(mod_code)
    );

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (integ_q == '0)) else $error("reset value"); // R1
endmodule

// File: tb/tb_fll_integrator.sv
`timescale 1ns/1ps
module tb_fll_integrator;
    logic       clk = 1'b0, rst_n = 1'b0, ref_clk = 1'b0, osc_clk = 1'b0;
    logic [1:0] div_sel = 2'd1;
    logic [6:0] mult_n = 7'd3;
    logic       out_undiv = 1'b0, mod_off = 1'b0;
    logic [4:0] tap_sel, mod_code;
    logic       osc_out;
    logic [9:0] integ_q;

    int  n_chk = 0, n_bad = 0, osc_mode = 0, osc_burst = 0, edge_cnt = 0;
    bit  done = 1'b0;
    real osc_x;

    typedef struct { string tag; int rb; int tap; int md; } exp_t;
    exp_t sb_q[$];

    always #2 clk = ~clk;  // 250 MHz

    fll_integrator dut (
        .clk(clk), .rst_n(rst_n), .ref_clk(ref_clk), .osc_clk(osc_clk),
        .div_sel(div_sel), .mult_n(mult_n), .out_undiv(out_undiv), .mod_off(mod_off),
        .tap_sel(tap_sel), .mod_code(mod_code), .osc_out(osc_out), .integ_q(integ_q)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pops scoreboard items and compares against the outputs.
    always @(negedge clk) begin
        exp_t e;
        if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            chk({e.tag, " integ_q"}, int'(integ_q), e.rb);
            chk({e.tag, " tap_sel"}, int'(tap_sel), e.tap);
            chk({e.tag, " mod_code"}, int'(mod_code), e.md);
        end
    end

    // Driver side: settle, then queue the expected outputs.
    task automatic expect_out(string tag, int rb, int tap, int md);
        repeat (24) @(negedge clk);
        sb_q.push_back('{tag, rb, tap, md});
        repeat (2) @(negedge clk);
    endtask

    // Oscillator model: bursts, follow-the-reference, or tap-driven period.
    initial forever begin
        if (osc_mode == 2) begin
            osc_x = real'(tap_sel) + real'(mod_code) / 32.0;
            #(100.0 * (0.9 ** osc_x)) osc_clk = ~osc_clk;
        end else if (osc_mode == 3) begin
            @(ref_clk or osc_mode);
            if (osc_mode == 3) osc_clk = ref_clk;
        end else if (osc_burst > 0) begin
            #10 osc_clk = 1'b1;
            #10 osc_clk = 1'b0;
            osc_burst--;
        end else begin
            #2;
        end
    end

    always @(posedge osc_out) edge_cnt++;

    task automatic osc_pulses(int n);
        osc_burst = n;
        wait (osc_burst == 0);
        @(negedge clk);
    endtask

    task automatic ref_pulses(int k, real half);
        @(negedge clk);
        repeat (k) begin
            #(half) ref_clk = 1'b1;
            #(half) ref_clk = 1'b0;
        end
    endtask

    task automatic measure(string tag, int exp_edges);
        osc_pulses(8);
        edge_cnt = 0;
        osc_pulses(16);
        chk(tag, edge_cnt, exp_edges);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        osc_burst = 10;
        repeat (60) @(negedge clk);
        wait (osc_burst == 0);
        rst_n = 1'b1;
        osc_pulses(2);                       // release oscillator-domain reset
        expect_out("R1 reset", 0, 0, 0);

        ref_pulses(40, 40.0);
        expect_out("R2 R8 count up 40", 40, 1, 8);
        mod_off = 1'b1;
        expect_out("R8 mod_off", 40, 1, 0);
        mod_off = 1'b0;

        osc_pulses(80);                      // D=2 N=3: 8 per step
        expect_out("R3 D2 N3 down", 30, 0, 30);
        div_sel = 2'd3;
        osc_pulses(64);                      // D=8 N=3: 32 per step
        expect_out("R3 D8 N3 down", 28, 0, 28);
        osc_pulses(1280);
        expect_out("R6 floor", 0, 0, 0);

        ref_pulses(20, 40.0);
        expect_out("R2 count up 20", 20, 0, 20);
        div_sel = 2'd0; mult_n = 7'd0;
        osc_mode = 3;
        ref_pulses(30, 40.0);
        expect_out("R4 equal rates", 20, 0, 20);
        osc_mode = 0;

        ref_pulses(1030, 12.0);
        expect_out("R5 R7 ceiling", 1023, 28, 31);
        div_sel = 2'd1; mult_n = 7'd3;
        osc_pulses(800);
        expect_out("R7 raw tap 28", 923, 28, 27);
        osc_pulses(320);
        expect_out("R7 R3 tap 27", 883, 27, 19);

        measure("R9 D2 divided", 8);
        out_undiv = 1'b1;
        measure("R9 undivided", 16);
        out_undiv = 1'b0; div_sel = 2'd2;
        measure("R9 D4 divided", 4);
        div_sel = 2'd3;
        measure("R9 D8 divided", 2);
        div_sel = 2'd0;
        measure("R9 D1 divided", 16);

        div_sel = 2'd1; mult_n = 7'd3;       // target 8x reference
        osc_mode = 2;
        ref_pulses(700, 200.0);
        chk("R10 lock integ range", int'(integ_q >= 10'd400 && integ_q <= 10'd445), 1);
        chk("R10 lock tap", int'(tap_sel == 5'd12 || tap_sel == 5'd13), 1);
        osc_mode = 0;

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule